// File: doc/BRIEF.md
# TDMA Frame and Slot Sequencer

This block produces the slot timing of a time-division link layer. A one-cycle cycle-start strobe from the sync timebase restarts it at frame 0, slot 0. From there it counts clock ticks inside each slot, slots inside each frame and frames inside each cycle. Each slot is classed as transmit, receive or idle. That choice uses the transmit and receive bit masks, the slot's place in the frame and a rate index that thins out the active frames. For the current slot the block then drives the radio controls: a receive enable, a one-cycle transmit start and a sleep request.

Every slot has its own sub-phases. A transmit slot holds a guard time before the send strobe and then keeps the radio awake for the longest packet. A receive slot listens at once and gives up after a short timeout unless a preamble shows up. Every slot ends with a quiet spacing window. The last few slots of each frame form a contention region, where the node only ever listens. The current frame and slot numbers are brought out for packet headers. All durations are parameters in clock ticks, so simulations can run at a scaled rate.

Top module: `tdma_slot_sequencer`

## Requirements
- R1: After reset, and until the first cycle-start strobe, the block is idle: sleep is 1, rxEnable and txStart are 0, frameNum and slotNum are 0 and do not change.
- R2: A cycle-start strobe, including one in the middle of a cycle, makes the next clock show frame 0, slot 0, tick 0.
- R3: slotNum advances every SLOT_TICKS clocks. It wraps from NUM_SLOTS-1 to 0 while frameNum advances, and frameNum wraps from NUM_FRAMES-1 to 0.
- R4: In an active non-contention slot whose transmit mask bit is set, txStart is a single-cycle pulse at tick GUARD_TICKS of the slot. The mask bit index equals the slot number.
- R5: In an active receive slot, rxEnable is 1 from tick 0. It goes to 0 at tick RX_TIMEOUT_TICKS if no preamble was seen.
- R6: A preamble seen while rxEnable is 1 keeps rxEnable at 1 until tick SLOT_TICKS-SPACING_TICKS. A preamble seen while rxEnable is 0 has no effect.
- R7: A non-contention slot with both mask bits set is a transmit slot: txStart pulses and rxEnable stays 0.
- R8: With rate index r of 0 or 1, every frame is active. With r of 2 or more, only frames whose number is a multiple of 2^(r-1) are active. If that value is 32 or more, only frame 0 is active. In inactive frames no slot is active.
- R9: In the last CONT_SLOTS slots of a frame, txStart never fires. A set transmit or receive bit makes the slot a listen-only slot, with the same timeout as R5.
- R10: sleep is 0 exactly while one of these holds: rxEnable is 1; the slot is a transmit slot with tick below GUARD_TICKS+MAX_PKT_TICKS; or the tick is in the last WAKE_TICKS of a slot whose successor is active. The successor may lie in the next frame or the next cycle.
- R11: frameNum and slotNum always show the position of the slot in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycleStart | input | 1 | One-cycle strobe that starts a cycle at frame 0, slot 0 |
| txMask | input | NUM_SLOTS | Transmit bit per slot |
| rxMask | input | NUM_SLOTS | Receive bit per slot |
| rateIdx | input | 4 | Frame rate index r (active every 2^(r-1)-th frame) |
| preambleDet | input | 1 | Preamble detected by the radio |
| rxEnable | output | 1 | Receiver enable |
| txStart | output | 1 | One-cycle start of packet transmission |
| sleep | output | 1 | Radio sleep request |
| frameNum | output | 5 | Current frame number |
| slotNum | output | 5 | Current slot number |

## Verification
Some properties are checked on every cycle. The transmit strobe never lasts more than one cycle, and it never fires in a contention slot or together with the receiver. The radio is never asleep while receiving, and the block stays asleep before the first cycle start. The slot counter steps by one on each slot boundary, and a cycle start always lands on frame 0, slot 0. Other behaviours need the bench's scenarios to show. These cover timing: the guard offset, the receive timeout, and a preamble extending the listen window while a late one is ignored. They also cover rate thinning across frames, and the early wake before a slot in the next frame or next cycle.

// File: rtl/tdma_seq_pkg.sv
package tdma_seq_pkg;
  typedef enum logic [1:0] {
    KIND_IDLE = 2'd0,
    KIND_TX   = 2'd1,
    KIND_RX   = 2'd2
  } slotKind_e;

  // control -> datapath strobes
  typedef struct packed {
    logic restart;
    logic advance;
  } seqStrobe_t;
endpackage

// File: rtl/tdma_seq_datapath.sv
module tdma_seq_datapath
  import tdma_seq_pkg::*;
#(
  parameter int NUM_FRAMES = 32,
  parameter int NUM_SLOTS  = 32,
  parameter int CONT_SLOTS = 8,
  parameter int RATE_W     = 4,
  localparam int FRAME_W   = $clog2(NUM_FRAMES),
  localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           strobe,
  input  logic [NUM_SLOTS-1:0] txMask,
  input  logic [NUM_SLOTS-1:0] rxMask,
  input  logic [RATE_W-1:0]    rateIdx,
  output logic [FRAME_W-1:0]   frameNum,
  output logic [SLOT_W-1:0]    slotNum,
  output slotKind_e            curKind,
  output logic                 nextActive,
  output logic                 contSlot
);
  localparam int CONT_FIRST = NUM_SLOTS - CONT_SLOTS;

  logic [FRAME_W-1:0] nextFrame;
  logic [SLOT_W-1:0]  nextSlot;
  logic               lastSlot;

  function automatic logic frameOn(input logic [FRAME_W-1:0] fr,
                                   input logic [RATE_W-1:0] r);
    int          shift;
    logic [31:0] low;
    if (r <= RATE_W'(1)) return 1'b1;
    shift = int'(r) - 1;
    if (shift >= FRAME_W) return fr == '0;
    low = (32'd1 << shift) - 32'd1;
    return (fr & low[FRAME_W-1:0]) == '0;
  endfunction

  function automatic logic isCont(input logic [SLOT_W-1:0] sl);
    return {1'b0, sl} >= (SLOT_W+1)'(CONT_FIRST);
  endfunction

  function automatic slotKind_e kindOf(input logic [FRAME_W-1:0] fr,
                                       input logic [SLOT_W-1:0] sl,
                                       input logic [NUM_SLOTS-1:0] tm,
                                       input logic [NUM_SLOTS-1:0] rm,
                                       input logic [RATE_W-1:0] r,
                                       input logic contOk);
    if (!frameOn(fr, r)) return KIND_IDLE;
    if (contOk && isCont(sl)) return (tm[sl] || rm[sl]) ? KIND_RX : KIND_IDLE;
    if (tm[sl]) return KIND_TX;
    if (rm[sl]) return KIND_RX;
    return KIND_IDLE;
  endfunction

  generate
    if (CONT_SLOTS > 0) begin : g_cont
      assign contSlot = isCont(slotNum);
      always_comb curKind = kindOf(frameNum, slotNum, txMask, rxMask, rateIdx, 1'b1);
      always_comb nextActive =
        kindOf(nextFrame, nextSlot, txMask, rxMask, rateIdx, 1'b1) != KIND_IDLE;
    end else begin : g_nocont
      assign contSlot = 1'b0;
      always_comb curKind = kindOf(frameNum, slotNum, txMask, rxMask, rateIdx, 1'b0);
      always_comb nextActive =
        kindOf(nextFrame, nextSlot, txMask, rxMask, rateIdx, 1'b0) != KIND_IDLE;
    end
  endgenerate

  always_comb begin
    lastSlot = slotNum == SLOT_W'(NUM_SLOTS - 1);
    nextSlot = lastSlot ? '0 : slotNum + 1'b1;
    if (!lastSlot) nextFrame = frameNum;
    else if (frameNum == FRAME_W'(NUM_FRAMES - 1)) nextFrame = '0;
    else nextFrame = frameNum + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameNum <= '0;
      slotNum  <= '0;
    end else if (strobe.restart) begin
      frameNum <= '0;
      slotNum  <= '0;
    end else if (strobe.advance) begin
      frameNum <= nextFrame;
      slotNum  <= nextSlot;
    end
  end

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> (frameNum == '0 && slotNum == '0)); // R2
  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.restart) |=> slotNum == SLOT_W'($past(slotNum) + 1'b1)); // R3
endmodule

// File: rtl/tdma_seq_control.sv
module tdma_seq_control
  import tdma_seq_pkg::*;
#(
  parameter int SLOT_TICKS       = 50,
  parameter int GUARD_TICKS      = 1,
  parameter int RX_TIMEOUT_TICKS = 3,
  parameter int MAX_PKT_TICKS    = 40,
  parameter int SPACING_TICKS    = 5,
  parameter int WAKE_TICKS       = 2,
  localparam int TICK_W          = $clog2(SLOT_TICKS + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cycleStart,
  input  logic       preambleDet,
  input  slotKind_e  curKind,
  input  logic       nextActive,
  input  logic       contSlot,
  output seqStrobe_t strobe,
  output logic       rxEnable,
  output logic       txStart,
  output logic       sleep
);
  localparam int DATA_END  = SLOT_TICKS - SPACING_TICKS;
  localparam int TX_END    = GUARD_TICKS + MAX_PKT_TICKS;
  localparam int WAKE_FROM = SLOT_TICKS - WAKE_TICKS;

  logic [TICK_W-1:0] tickCnt;
  logic              running;
  logic              rxHeld;
  logic              lastTick;
  logic              txWindow;
  logic              wakeAhead;

  assign lastTick       = tickCnt == TICK_W'(SLOT_TICKS - 1);
  assign strobe.restart = cycleStart;
  assign strobe.advance = running && lastTick && !cycleStart;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      tickCnt <= '0;
      rxHeld  <= 1'b0;
    end else if (cycleStart) begin
      running <= 1'b1;
      tickCnt <= '0;
      rxHeld  <= 1'b0;
    end else if (running) begin
      if (lastTick) begin
        tickCnt <= '0;
        rxHeld  <= 1'b0;
      end else begin
        tickCnt <= tickCnt + 1'b1;
        if (rxEnable && preambleDet) rxHeld <= 1'b1;
      end
    end
  end

  always_comb begin
    rxEnable  = running && curKind == KIND_RX &&
                (tickCnt < TICK_W'(RX_TIMEOUT_TICKS) ||
                 (rxHeld && tickCnt < TICK_W'(DATA_END)));
    txStart   = running && curKind == KIND_TX && tickCnt == TICK_W'(GUARD_TICKS);
    txWindow  = running && curKind == KIND_TX && tickCnt < TICK_W'(TX_END);
    wakeAhead = running && nextActive && tickCnt >= TICK_W'(WAKE_FROM);
    sleep     = !(rxEnable || txWindow || wakeAhead);
  end

  AST_TX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    txStart |=> !txStart); // R4
  AST_TX_NOT_CONT: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> !contSlot); // R9
  AST_TX_RX_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(txStart && rxEnable)); // R7
  AST_RX_AWAKE: assert property (@(posedge clk) disable iff (!rstN)
    rxEnable |-> !sleep); // R10
  AST_IDLE_ASLEEP: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (sleep && !rxEnable && !txStart)); // R1
endmodule

// File: rtl/tdma_slot_sequencer.sv
module tdma_slot_sequencer
  import tdma_seq_pkg::*;
#(
  parameter int NUM_FRAMES       = 32,
  parameter int NUM_SLOTS        = 32,
  parameter int CONT_SLOTS       = 8,
  parameter int SLOT_TICKS       = 50,
  parameter int GUARD_TICKS      = 1,
  parameter int RX_TIMEOUT_TICKS = 3,
  parameter int MAX_PKT_TICKS    = 40,
  parameter int SPACING_TICKS    = 5,
  parameter int WAKE_TICKS       = 2,
  localparam int FRAME_W         = $clog2(NUM_FRAMES),
  localparam int SLOT_W          = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cycleStart,
  input  logic [NUM_SLOTS-1:0] txMask,
  input  logic [NUM_SLOTS-1:0] rxMask,
  input  logic [3:0]           rateIdx,
  input  logic                 preambleDet,
  output logic                 rxEnable,
  output logic                 txStart,
  output logic                 sleep,
  output logic [FRAME_W-1:0]   frameNum,
  output logic [SLOT_W-1:0]    slotNum
);
  seqStrobe_t strobe;
  slotKind_e  curKind;
  logic       nextActive;
  logic       contSlot;

  tdma_seq_control #(
    .SLOT_TICKS(SLOT_TICKS), .GUARD_TICKS(GUARD_TICKS),
    .RX_TIMEOUT_TICKS(RX_TIMEOUT_TICKS), .MAX_PKT_TICKS(MAX_PKT_TICKS),
    .SPACING_TICKS(SPACING_TICKS), .WAKE_TICKS(WAKE_TICKS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cycleStart(cycleStart), .preambleDet(preambleDet),
    .curKind(curKind), .nextActive(nextActive), .contSlot(contSlot),
    .strobe(strobe), .rxEnable(rxEnable), .txStart(txStart), .sleep(sleep)
  );

  tdma_seq_datapath #(
    .NUM_FRAMES(NUM_FRAMES), .NUM_SLOTS(NUM_SLOTS),
    .CONT_SLOTS(CONT_SLOTS), .RATE_W(4)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txMask(txMask), .rxMask(rxMask),
    .rateIdx(rateIdx), .frameNum(frameNum), .slotNum(slotNum),
    .curKind(curKind), .nextActive(nextActive), .contSlot(contSlot)
  );
endmodule

// File: tb/tdma_slot_sequencer_tb.sv
module tdma_slot_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SLOT_T  = 20;
  localparam int FRAME_T = 32 * SLOT_T;
  localparam int WD_CYCLES = 190000;
  localparam logic [5:0] NOPRE = 6'd63;

  typedef struct packed {
    logic [31:0] txm;
    logic [31:0] rxm;
    logic [3:0]  rate;
    logic [5:0]  pre;
    logic [4:0]  fr;
    logic [4:0]  sl;
    logic [4:0]  tk;
    logic        eRx;
    logic        eTx;
    logic        eSl;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{32'h4, 32'h0, 4'd1, NOPRE, 5'd0, 5'd2, 5'd1,  1'b0, 1'b1, 1'b0, 4'd4},  // R4 guard
    '{32'h4, 32'h0, 4'd1, NOPRE, 5'd0, 5'd2, 5'd0,  1'b0, 1'b0, 1'b0, 4'd10}, // R10
    '{32'h4, 32'h0, 4'd1, NOPRE, 5'd0, 5'd2, 5'd12, 1'b0, 1'b0, 1'b0, 4'd10}, // R10
    '{32'h4, 32'h0, 4'd1, NOPRE, 5'd0, 5'd2, 5'd13, 1'b0, 1'b0, 1'b1, 4'd10}, // R10
    '{32'h0, 32'h20, 4'd1, NOPRE, 5'd0, 5'd5, 5'd2, 1'b1, 1'b0, 1'b0, 4'd5},  // R5
    '{32'h0, 32'h20, 4'd1, NOPRE, 5'd0, 5'd5, 5'd3, 1'b0, 1'b0, 1'b1, 4'd5},  // R5
    '{32'h0, 32'h20, 4'd1, 6'd2, 5'd0, 5'd5, 5'd10, 1'b1, 1'b0, 1'b0, 4'd6},  // R6
    '{32'h0, 32'h20, 4'd1, 6'd2, 5'd0, 5'd5, 5'd15, 1'b1, 1'b0, 1'b0, 4'd6},  // R6
    '{32'h0, 32'h20, 4'd1, 6'd2, 5'd0, 5'd5, 5'd16, 1'b0, 1'b0, 1'b1, 4'd6},  // R6
    '{32'h0, 32'h20, 4'd1, 6'd5, 5'd0, 5'd5, 5'd6,  1'b0, 1'b0, 1'b1, 4'd6},  // R6 late
    '{32'h80, 32'h80, 4'd1, NOPRE, 5'd0, 5'd7, 5'd1, 1'b0, 1'b1, 1'b0, 4'd7}, // R7
    '{32'h80, 32'h80, 4'd1, NOPRE, 5'd0, 5'd7, 5'd2, 1'b0, 1'b0, 1'b0, 4'd7}, // R7
    '{32'h100, 32'h0, 4'd1, NOPRE, 5'd0, 5'd7, 5'd18, 1'b0, 1'b0, 1'b0, 4'd10}, // R10 wake
    '{32'h100, 32'h0, 4'd1, NOPRE, 5'd0, 5'd7, 5'd17, 1'b0, 1'b0, 1'b1, 4'd10}, // R10
    '{32'h0, 32'h10, 4'd3, NOPRE, 5'd1, 5'd4, 5'd0, 1'b0, 1'b0, 1'b1, 4'd8},  // R8
    '{32'h0, 32'h10, 4'd3, NOPRE, 5'd4, 5'd4, 5'd0, 1'b1, 1'b0, 1'b0, 4'd8},  // R8
    '{32'h0, 32'h10, 4'd3, NOPRE, 5'd2, 5'd4, 5'd0, 1'b0, 1'b0, 1'b1, 4'd8},  // R8
    '{32'h0, 32'h10, 4'd0, NOPRE, 5'd3, 5'd4, 5'd0, 1'b1, 1'b0, 1'b0, 4'd8},  // R8
    '{32'h0, 32'h10, 4'd15, NOPRE, 5'd16, 5'd4, 5'd0, 1'b0, 1'b0, 1'b1, 4'd8}, // R8
    '{32'h04000000, 32'h0, 4'd1, NOPRE, 5'd0, 5'd26, 5'd1, 1'b1, 1'b0, 1'b0, 4'd9}, // R9
    '{32'h04000000, 32'h0, 4'd1, NOPRE, 5'd0, 5'd26, 5'd3, 1'b0, 1'b0, 1'b1, 4'd9}, // R9
    '{32'h0, 32'h1, 4'd1, NOPRE, 5'd0, 5'd31, 5'd18, 1'b0, 1'b0, 1'b0, 4'd10}, // R10 frame edge
    '{32'h0, 32'h1, 4'd2, NOPRE, 5'd0, 5'd31, 5'd18, 1'b0, 1'b0, 1'b1, 4'd10}, // R10
    '{32'h0, 32'h1, 4'd2, NOPRE, 5'd1, 5'd31, 5'd19, 1'b0, 1'b0, 1'b0, 4'd10}, // R10
    '{32'h0, 32'h1, 4'd15, NOPRE, 5'd31, 5'd31, 5'd18, 1'b0, 1'b0, 1'b0, 4'd3} // R3 cycle edge
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cycleStart = 1'b0;
  logic [31:0] txMask = '0;
  logic [31:0] rxMask = '0;
  logic [3:0]  rateIdx = 4'd1;
  logic        preambleDet = 1'b0;
  logic        rxEnable, txStart, sleep;
  logic [4:0]  frameNum, slotNum;
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tdma_slot_sequencer #(
    .SLOT_TICKS(SLOT_T), .GUARD_TICKS(1), .RX_TIMEOUT_TICKS(3),
    .MAX_PKT_TICKS(12), .SPACING_TICKS(4), .WAKE_TICKS(2)
  ) dut_i (
    .clk(clk), .rstN(rstN), .cycleStart(cycleStart), .txMask(txMask),
    .rxMask(rxMask), .rateIdx(rateIdx), .preambleDet(preambleDet),
    .rxEnable(rxEnable), .txStart(txStart), .sleep(sleep),
    .frameNum(frameNum), .slotNum(slotNum)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // pulse cycleStart, then step to absolute position pos; preamble high at position preAt
  task automatic runTo(input int pos, input int preAt);
    cycleStart = 1'b1;
    @(negedge clk);
    cycleStart = 1'b0;
    for (int q = 0; q < pos; q++) begin
      preambleDet = (q == preAt);
      @(negedge clk);
    end
    preambleDet = 1'b0;
  endtask

  task automatic outs(input string req, input logic eRx, input logic eTx, input logic eSl);
    chk(req, "rxEnable", 32'(rxEnable), 32'(eRx));
    chk(req, "txStart", 32'(txStart), 32'(eTx));
    chk(req, "sleep", 32'(sleep), 32'(eSl));
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=done");
    summary();
  end

  initial begin
    string tag;
    int pos, preAt, base;
    repeat (3) @(negedge clk);
    // R1: reset state
    outs("R1", 1'b0, 1'b0, 1'b1);
    chk("R1", "frameNum", 32'(frameNum), 0);
    rstN = 1'b1;
    txMask = 32'hFFFF_FFFF;
    rxMask = 32'hFFFF_FFFF;
    repeat (45) @(negedge clk);
    // R1: no counting or activity before the first cycle start
    outs("R1", 1'b0, 1'b0, 1'b1);
    chk("R1", "slotNum idle", 32'(slotNum), 0);
    chk("R1", "frameNum idle", 32'(frameNum), 0);

    for (int i = 0; i < NV; i++) begin
      tag = $sformatf("R%0d", VECS[i].req);
      txMask = VECS[i].txm;
      rxMask = VECS[i].rxm;
      rateIdx = VECS[i].rate;
      base = int'(VECS[i].fr) * FRAME_T + int'(VECS[i].sl) * SLOT_T;
      pos = base + int'(VECS[i].tk);
      preAt = (VECS[i].pre == NOPRE) ? -1 : base + int'(VECS[i].pre);
      runTo(pos, preAt);
      outs(tag, VECS[i].eRx, VECS[i].eTx, VECS[i].eSl);
      chk("R11", "frameNum", 32'(frameNum), 32'(VECS[i].fr));
      chk("R11", "slotNum", 32'(slotNum), 32'(VECS[i].sl));
    end

    // R3: cycle wraps to frame 0 slot 0, which is active with rate 15 and bit 0
    txMask = '0; rxMask = 32'h1; rateIdx = 4'd15;
    runTo(32 * FRAME_T, -1);
    chk("R3", "frameNum wrap", 32'(frameNum), 0);
    chk("R3", "slotNum wrap", 32'(slotNum), 0);
    chk("R3", "rxEnable at wrap", 32'(rxEnable), 1);

    // R2: mid-cycle restart
    txMask = '0; rxMask = '0; rateIdx = 4'd1;
    runTo(FRAME_T + 3 * SLOT_T + 7, -1);
    chk("R11", "slotNum before restart", 32'(slotNum), 3);
    runTo(0, -1);
    chk("R2", "frameNum restart", 32'(frameNum), 0);
    chk("R2", "slotNum restart", 32'(slotNum), 0);
    repeat (SLOT_T - 1) @(negedge clk);
    chk("R3", "slot held until boundary", 32'(slotNum), 0);
    @(negedge clk);
    chk("R3", "slot advanced", 32'(slotNum), 1);

    // R1: reset while running returns to idle
    txMask = 32'hFFFF_FFFF;
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    repeat (30) @(negedge clk);
    outs("R1", 1'b0, 1'b0, 1'b1);
    chk("R1", "slotNum after reset", 32'(slotNum), 0);
    summary();
  end
endmodule